// File: doc/BRIEF.md
# Priority Interrupt Arbiter With Mask

This block collects every interrupt request in the system and offers the processor at most one of them at a time. It has three kinds of source. The first is a non-maskable request, detected on a selectable pin edge. The second is eight external pins, each of which senses either a low level or a falling edge. The third is a parameterised group of peripheral requests. A maskable source carries a 4-bit level, and level 0 turns that source off. The non-maskable source sits above every maskable one at level 16.

Each cycle the block picks the strongest eligible request. A maskable request is eligible only when its level is above the 4-bit mask that the processor presents. The block registers the choice and raises a request line with the winner's identifier. The processor answers with an accept strobe. The block then pulses an acknowledge, a one-hot vector that names the source, and the mask value the processor should load. That vector also clears the latched edge of the accepted source.

Top module: `irq_arb`

## Requirements
- R1: The non-maskable source latches on a rising edge of `nmi_pin_i` when `nmi_rise_i`=1 and on a falling edge when `nmi_rise_i`=0. The latched request stays pending until it is accepted.
- R2: The non-maskable source has identifier 0 and level 16. While pending it wins over every other source whatever the value of `mask_i`.
- R3: Accepting identifier 0 gives `new_mask_o`=15.
- R4: With `ext_edge_i[k]`=0, pin k requests for as long as it is low. With `ext_edge_i[k]`=1, a high-to-low change on pin k latches a request that stays pending after the pin returns high, until it is accepted.
- R5: Pin k for k<4 takes its level from `prio_a_i[4k+3:4k]`. Pin k for k>=4 takes its level from `prio_b_i[4(k-4)+3:4(k-4)]`. Peripheral j requests for as long as `peri_req_i[j]`=1 and takes its level from `peri_prio_i[4j+3:4j]`.
- R6: A maskable source whose level is 0 never raises `irq_o`.
- R7: A maskable source is offered only if its level is strictly greater than `mask_i`.
- R8: The highest level wins. On a tie the lowest identifier wins. Identifiers are 0 for the non-maskable source, 1+k for pin k and 9+j for peripheral j, so pins beat peripherals.
- R9: `irq_o` and `src_id_o` are registered. They reflect the inputs present before the most recent clock edge, and a new request appears one edge after it is driven.
- R10: When `accept_i`=1 while `irq_o`=1, the next cycle gives the following: `ack_o`=1 for exactly one cycle, `ack_vec_o` with a single bit set at index `src_id_o`, and `irq_o`=0 for that cycle.
- R11: Accepting a maskable source gives `new_mask_o` equal to that source's level.
- R12: `accept_i` while `irq_o`=0 is ignored. `ack_o` stays 0 and `new_mask_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_pin_i | input | 1 | Non-maskable request pin |
| nmi_rise_i | input | 1 | 1 selects the rising edge, 0 selects the falling edge |
| ext_pin_i | input | 8 | External request pins, active low |
| ext_edge_i | input | 8 | Per-pin sense: 1 for falling edge, 0 for low level |
| prio_a_i | input | 16 | Levels of pins 0..3, four bits each |
| prio_b_i | input | 16 | Levels of pins 4..7, four bits each |
| peri_req_i | input | NUM_PERI | Peripheral level requests |
| peri_prio_i | input | 4*NUM_PERI | Peripheral levels, four bits each |
| mask_i | input | 4 | Current processor mask level |
| accept_i | input | 1 | Processor takes the offered request |
| irq_o | output | 1 | Request offered to the processor |
| src_id_o | output | ID_W | Identifier of the offered source |
| new_mask_o | output | 4 | Mask level to load after acceptance |
| ack_o | output | 1 | One-cycle acknowledge pulse |
| ack_vec_o | output | NUM_SRC | One-hot acknowledge per source |

## Verification
The bench builds the block with NUM_PERI=2, so there are eleven sources and a 4-bit identifier. That size lets it sweep every external pin against every 4-bit level and every mask value, which covers the strict-greater rule, the zero-level case and the field packing across both priority words. Pairwise tie sweeps cover the ordering among pins and between pins and peripherals. Directed sequences cover both edge polarities of the non-maskable input, a latched edge surviving the pin's return to high, the acknowledge timing for every level, and an accept strobe sent with nothing offered.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    localparam int NUM_EXT   = 8;
    localparam int FIELD_W   = 4;
    localparam int LVL_W     = FIELD_W + 1;
    localparam int EXT_BASE  = 1;
    localparam int PERI_BASE = EXT_BASE + NUM_EXT;

    typedef logic [LVL_W-1:0]   lvl_t;
    typedef logic [FIELD_W-1:0] mask_t;

    localparam lvl_t  TOP_LVL  = lvl_t'(16);
    localparam mask_t TOP_MASK = mask_t'(15);

    typedef enum logic {
        SENSE_LOW  = 1'b0,
        SENSE_FALL = 1'b1
    } sense_e;

    typedef struct packed {
        logic valid;
        lvl_t lvl;
    } grant_t;

    function automatic lvl_t pin_level(input logic [15:0] word_a,
                                       input logic [15:0] word_b,
                                       input int          pin);
        logic [31:0] both;
        both = {word_b, word_a} >> (FIELD_W * pin);
        return {1'b0, both[FIELD_W-1:0]};
    endfunction

    function automatic lvl_t field_level(input mask_t f);
        return {1'b0, f};
    endfunction

endpackage

// File: rtl/irq_sense.sv
module irq_sense
    import irq_arb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    input  logic mode,
    input  logic clr,
    output logic req
);
    logic   prev_q;
    logic   flag_q;
    sense_e sense;

    assign sense = sense_e'(mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= pin_n;
            flag_q <= 1'b0;
        end else begin
            prev_q <= pin_n;
            if (sense == SENSE_FALL)
                flag_q <= (flag_q & ~clr) | (prev_q & ~pin_n);
            else
                flag_q <= 1'b0;
        end
    end

    assign req = (sense == SENSE_FALL) ? flag_q : ~pin_n;

    AST_EDGE_HELD: assert property (@(posedge clk) disable iff (rst)
        (mode && flag_q && !clr) |=> flag_q); // R4

endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_arb_pkg::*;
#(
    parameter int NUM_SRC = 13,
    localparam int ID_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]            req,
    input  logic [NUM_SRC-1:0][LVL_W-1:0] lvl,
    input  mask_t                         mask,
    output grant_t                        grant,
    output logic [ID_W-1:0]               id
);
    logic [NUM_SRC-1:0] elig;

    generate
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_elig
            if (s == 0) begin : g_top
                assign elig[s] = req[s];
            end else begin : g_maskable
                assign elig[s] = req[s] && (lvl[s] > field_level(mask));
            end
        end
    endgenerate

    always_comb begin
        grant.valid = 1'b0;
        grant.lvl   = '0;
        id          = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (elig[s] && (lvl[s] > grant.lvl)) begin
                grant.valid = 1'b1;
                grant.lvl   = lvl[s];
                id          = ID_W'(s);
            end
        end
    end

endmodule

// File: rtl/irq_arb.sv
module irq_arb
    import irq_arb_pkg::*;
#(
    parameter int NUM_PERI = 4,
    localparam int NUM_SRC = PERI_BASE + NUM_PERI,
    localparam int ID_W    = $clog2(NUM_SRC)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    nmi_pin_i,
    input  logic                    nmi_rise_i,
    input  logic [NUM_EXT-1:0]      ext_pin_i,
    input  logic [NUM_EXT-1:0]      ext_edge_i,
    input  logic [15:0]             prio_a_i,
    input  logic [15:0]             prio_b_i,
    input  logic [NUM_PERI-1:0]     peri_req_i,
    input  logic [4*NUM_PERI-1:0]   peri_prio_i,
    input  logic [3:0]              mask_i,
    input  logic                    accept_i,
    output logic                    irq_o,
    output logic [ID_W-1:0]         src_id_o,
    output logic [3:0]              new_mask_o,
    output logic                    ack_o,
    output logic [NUM_SRC-1:0]      ack_vec_o
);
    logic [NUM_SRC-1:0]            src_req;
    logic [NUM_SRC-1:0][LVL_W-1:0] src_lvl;
    logic [NUM_SRC-1:0]            clr_vec;
    grant_t                        win;
    logic [ID_W-1:0]               win_id;
    logic                          take;

    logic                          irq_q;
    logic [ID_W-1:0]               id_q;
    lvl_t                          lvl_q;
    logic                          ack_q;
    logic [NUM_SRC-1:0]            ack_vec_q;
    mask_t                         new_mask_q;

    logic                          nmi_prev_q;
    logic                          nmi_flag_q;
    logic                          nmi_edge;

    assign take    = accept_i && irq_q;
    assign clr_vec = take ? (NUM_SRC'(1) << id_q) : '0;

    // non-maskable source, selectable edge
    assign nmi_edge = nmi_rise_i ? (~nmi_prev_q & nmi_pin_i)
                                 : (nmi_prev_q & ~nmi_pin_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_prev_q <= nmi_pin_i;
            nmi_flag_q <= 1'b0;
        end else begin
            nmi_prev_q <= nmi_pin_i;
            nmi_flag_q <= (nmi_flag_q & ~clr_vec[0]) | nmi_edge;
        end
    end

    assign src_req[0] = nmi_flag_q;
    assign src_lvl[0] = TOP_LVL;

    generate
        for (genvar k = 0; k < NUM_EXT; k++) begin : g_ext
            irq_sense u_sense (
                .clk   (clk),
                .rst   (rst),
                .pin_n (ext_pin_i[k]),
                .mode  (ext_edge_i[k]),
                .clr   (clr_vec[EXT_BASE+k]),
                .req   (src_req[EXT_BASE+k])
            );
            assign src_lvl[EXT_BASE+k] = pin_level(prio_a_i, prio_b_i, k);
        end
        for (genvar j = 0; j < NUM_PERI; j++) begin : g_peri
            assign src_req[PERI_BASE+j] = peri_req_i[j];
            assign src_lvl[PERI_BASE+j] = field_level(peri_prio_i[FIELD_W*j +: FIELD_W]);
        end
    endgenerate

    irq_pick #(.NUM_SRC(NUM_SRC)) u_pick (
        .req   (src_req),
        .lvl   (src_lvl),
        .mask  (mask_i),
        .grant (win),
        .id    (win_id)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q      <= 1'b0;
            id_q       <= '0;
            lvl_q      <= '0;
            ack_q      <= 1'b0;
            ack_vec_q  <= '0;
            new_mask_q <= '0;
        end else begin
            irq_q     <= take ? 1'b0 : win.valid;
            id_q      <= win_id;
            lvl_q     <= win.lvl;
            ack_q     <= take;
            ack_vec_q <= clr_vec;
            if (take)
                new_mask_q <= (id_q == '0) ? TOP_MASK : lvl_q[FIELD_W-1:0];
        end
    end

    assign irq_o      = irq_q;
    assign src_id_o   = id_q;
    assign ack_o      = ack_q;
    assign ack_vec_o  = ack_vec_q;
    assign new_mask_o = new_mask_q;

    AST_ABOVE_MASK: assert property (@(posedge clk) disable iff (rst)
        (irq_o && src_id_o != '0) |-> (lvl_q > {1'b0, $past(mask_i)})); // R7
    AST_NO_ZERO_LVL: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (lvl_q != '0)); // R6
    AST_ACK_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (accept_i && irq_o) |=> (ack_o && !irq_o)); // R10
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ack_o |=> !ack_o); // R10
    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        ack_o |-> ($countones(ack_vec_o) == 1)); // R10
    AST_TOP_MASK: assert property (@(posedge clk) disable iff (rst)
        (accept_i && irq_o && src_id_o == '0) |=> (new_mask_o == 4'd15)); // R3
    AST_OWN_MASK: assert property (@(posedge clk) disable iff (rst)
        (accept_i && irq_o && src_id_o != '0) |=> (new_mask_o == $past(lvl_q[3:0]))); // R11
    AST_IGNORE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (accept_i && !irq_o) |=> (!ack_o && $stable(new_mask_o))); // R12

endmodule

// File: tb/irq_arb_tb.sv
module irq_arb_tb;
    localparam int NP   = 2;
    localparam int NSRC = 11;
    localparam int IDW  = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            nmi_pin_i = 1'b0;
    logic            nmi_rise_i = 1'b1;
    logic [7:0]      ext_pin_i = 8'hFF;
    logic [7:0]      ext_edge_i = 8'h00;
    logic [15:0]     prio_a_i = '0;
    logic [15:0]     prio_b_i = '0;
    logic [NP-1:0]   peri_req_i = '0;
    logic [4*NP-1:0] peri_prio_i = '0;
    logic [3:0]      mask_i = '0;
    logic            accept_i = 1'b0;
    logic            irq_o;
    logic [IDW-1:0]  src_id_o;
    logic [3:0]      new_mask_o;
    logic            ack_o;
    logic [NSRC-1:0] ack_vec_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    irq_arb #(.NUM_PERI(NP)) u_dut (
        .clk(clk), .rst(rst), .nmi_pin_i(nmi_pin_i), .nmi_rise_i(nmi_rise_i),
        .ext_pin_i(ext_pin_i), .ext_edge_i(ext_edge_i), .prio_a_i(prio_a_i),
        .prio_b_i(prio_b_i), .peri_req_i(peri_req_i), .peri_prio_i(peri_prio_i),
        .mask_i(mask_i), .accept_i(accept_i), .irq_o(irq_o), .src_id_o(src_id_o),
        .new_mask_o(new_mask_o), .ack_o(ack_o), .ack_vec_o(ack_vec_o)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] field(input int pin, input int lvl);
        return 32'(lvl) << (4 * pin);
    endfunction

    task automatic set_pin_prio(input int pin, input int lvl);
        logic [31:0] w;
        w = field(pin, lvl);
        prio_a_i = w[15:0];
        prio_b_i = w[31:16];
    endtask

    task automatic accept_and_check(input string req, input int exp_id, input int exp_mask);
        accept_i = 1'b1;
        tick();
        accept_i = 1'b0;
        chk({req, " ack"}, int'(ack_o), 1);
        chk({req, " new mask"}, int'(new_mask_o), exp_mask);
        chk({req, " ack vector"}, int'(ack_vec_o), 1 << exp_id);
        chk("R10 irq low during ack", int'(irq_o), 0);
        tick();
        chk("R10 ack single cycle", int'(ack_o), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tick();
        tick();
        rst = 1'b0;
        tick();
        chk("reset irq", int'(irq_o), 0);
        chk("reset ack", int'(ack_o), 0);
        chk("reset mask", int'(new_mask_o), 0);

        // R5 R6 R7 R9: sweep pin x level x mask, low-level sense
        for (int pin = 0; pin < 8; pin++) begin
            for (int lvl = 0; lvl < 16; lvl++) begin
                for (int m = 0; m < 16; m++) begin
                    set_pin_prio(pin, lvl);
                    mask_i = 4'(m);
                    ext_pin_i = ~(8'h01 << pin);
                    #1;
                    if (pin == 0 && m == 0)
                        chk("R9 not yet registered", int'(irq_o), 0);
                    tick();
                    chk("R5 R6 R7 offered", int'(irq_o), (lvl > m) ? 1 : 0);
                    if (lvl > m)
                        chk("R5 R8 identifier", int'(src_id_o), pin + 1);
                    ext_pin_i = 8'hFF;
                    tick();
                    chk("R4 level released", int'(irq_o), 0);
                end
            end
        end
        mask_i = 4'd0;

        // R8: ties between pins go to the lower pin
        for (int a = 0; a < 8; a++) begin
            for (int b = a + 1; b < 8; b++) begin
                logic [31:0] w;
                w = field(a, 9) | field(b, 9);
                prio_a_i = w[15:0];
                prio_b_i = w[31:16];
                ext_pin_i = ~((8'h01 << a) | (8'h01 << b));
                tick();
                chk("R8 pin tie", int'(src_id_o), a + 1);
                w = field(a, 8) | field(b, 9);
                prio_a_i = w[15:0];
                prio_b_i = w[31:16];
                tick();
                chk("R8 higher level wins", int'(src_id_o), b + 1);
                ext_pin_i = 8'hFF;
                tick();
            end
        end

        // R5 R8: pins against peripherals
        for (int pin = 0; pin < 8; pin++) begin
            for (int j = 0; j < NP; j++) begin
                set_pin_prio(pin, 9);
                ext_pin_i = ~(8'h01 << pin);
                peri_req_i = NP'(1) << j;
                peri_prio_i = (4*NP)'(9) << (4 * j);
                tick();
                chk("R8 pin beats peripheral on tie", int'(src_id_o), pin + 1);
                peri_prio_i = (4*NP)'(10) << (4 * j);
                tick();
                chk("R5 peripheral higher level", int'(src_id_o), 9 + j);
                ext_pin_i = 8'hFF;
                peri_req_i = '0;
                tick();
                chk("R5 peripheral released", int'(irq_o), 0);
            end
        end

        // R11 R10: accept a pin at every level
        for (int lvl = 1; lvl < 16; lvl++) begin
            set_pin_prio(5, lvl);
            ext_pin_i = ~8'h20;
            tick();
            accept_and_check("R11", 6, lvl);
            ext_pin_i = 8'hFF;
            tick();
        end

        // R4: falling edge latched and held after pin returns high
        ext_edge_i = 8'h08;
        set_pin_prio(3, 7);
        mask_i = 4'd2;
        ext_pin_i = 8'hF7;
        tick();
        ext_pin_i = 8'hFF;
        tick();
        chk("R4 edge latched", int'(irq_o), 1);
        chk("R4 edge id", int'(src_id_o), 4);
        tick();
        tick();
        chk("R4 edge held", int'(irq_o), 1);
        accept_and_check("R4 R11", 4, 7);
        chk("R4 edge cleared by accept", int'(irq_o), 0);
        ext_edge_i = 8'h00;

        // R12: accept with nothing offered
        accept_i = 1'b1;
        tick();
        accept_i = 1'b0;
        chk("R12 no ack", int'(ack_o), 0);
        chk("R12 mask kept", int'(new_mask_o), 7);

        // R1 R2 R3: rising edge, mask 15, pin at level 15 pending
        mask_i = 4'd15;
        set_pin_prio(0, 15);
        ext_pin_i = 8'hFE;
        nmi_rise_i = 1'b1;
        nmi_pin_i = 1'b1;
        tick();
        tick();
        chk("R2 top source offered", int'(irq_o), 1);
        chk("R2 top source id", int'(src_id_o), 0);
        mask_i = 4'd0;
        tick();
        chk("R2 wins over level 15", int'(src_id_o), 0);
        accept_and_check("R3", 0, 15);
        chk("R1 pending cleared", int'(src_id_o), 1);
        ext_pin_i = 8'hFF;
        tick();
        // falling edge ignored when rising selected
        nmi_pin_i = 1'b0;
        tick();
        tick();
        chk("R1 wrong edge ignored", int'(irq_o), 0);
        // falling edge selected
        nmi_rise_i = 1'b0;
        nmi_pin_i = 1'b1;
        tick();
        tick();
        chk("R1 rise ignored in fall mode", int'(irq_o), 0);
        nmi_pin_i = 1'b0;
        tick();
        tick();
        chk("R1 falling edge taken", int'(irq_o), 1);
        chk("R1 falling id", int'(src_id_o), 0);
        accept_and_check("R3", 0, 15);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule